// File: doc/BRIEF.md
# Pilot Distance Coefficient Generator

Once per frame this block turns two subcarrier masks (which subcarriers are in use, and which carry pilots) into two tables of interpolation weights, one entry per subcarrier. The right-weight table holds, for each subcarrier, its distance from the nearest pilot at or below it. This is the weight a linear interpolator applies to the upper pilot's estimate. The left-weight table holds the distance to the nearest pilot at or above it, which is the weight applied to the lower pilot's estimate. Both distances are measured in subcarrier index steps. A downstream interpolator reads both weights for one subcarrier index in a single access.

The generator fills the two tables in a fixed sequence:
1. One cycle sets every entry of both tables to one.
2. An ascending sweep builds the right weights.
3. A pass clears the right weights above the highest pilot.
4. A descending sweep builds the left weights.
5. A pass clears the left weights below the lowest pilot.

A one-cycle start request begins a frame, and a one-cycle done pulse ends it. The masks are captured when start is accepted.

Top module: `pdc_coef_gen`

## Requirements
- R1: When idle, a start_i high at a clock edge captures both masks. busy_o is high from the next cycle until the frame ends.
- R2: A start_i while busy_o is high is ignored. The masks are not recaptured, and the tables reflect the masks of the accepted start.
- R3: Subcarrier i is a pilot only when bit i of use_mask_i and bit i of pilot_mask_i are both 1. A pilot bit on an unused subcarrier has no effect.
- R4: For a subcarrier at or above the lowest pilot and at or below the highest pilot, the right weight equals the index minus the index of the nearest pilot at or below it. A pilot's own right weight is 0.
- R5: The right weight is 1 below the lowest pilot and 0 above the highest pilot.
- R6: For a subcarrier between the lowest and highest pilot, the left weight equals the index of the nearest pilot at or above it minus the index. A pilot's own left weight is 0.
- R7: The left weight is 0 below the lowest pilot and 1 above the highest pilot.
- R8: With no pilot at all, every right weight is 1, every left weight is 0, and done_o is still raised.
- R9: done_o is a single-cycle pulse with busy_o low. It arrives at most 390 cycles after the accepted start.
- R10: The read port samples rd_idx_i at a clock edge. Both weights for that index appear on rd_wgt_l_o and rd_wgt_r_o after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame start request |
| use_mask_i | input | 128 | Bit i set: subcarrier i in use |
| pilot_mask_i | input | 128 | Bit i set: subcarrier i marked as pilot |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse when both tables are final |
| rd_idx_i | input | 7 | Read subcarrier index |
| rd_wgt_l_o | output | 7 | Left weight for the read index |
| rd_wgt_r_o | output | 7 | Right weight for the read index |

## Verification
The assertions check several properties on every cycle:
- An accepted start raises busy.
- The captured masks stay frozen while busy.
- done lasts exactly one cycle.
- A pilot seen in the ascending sweep always writes a zero weight.
- The sweep index steps by one.
- The distance counter holds at its ceiling.

Only the bench's scenarios can show that the finished tables are right. The bench reads every entry back through the read port after runs with these mask patterns:
- spread pilots;
- adjacent pilots;
- a single pilot at either edge;
- no pilot;
- pilot bits on unused subcarriers;
- a second start arriving mid-frame.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_INIT, ST_FWD, ST_TRIM_R, ST_BWD, ST_TRIM_L, ST_DONE
  } pdc_state_e;
endpackage

// File: rtl/pdc_idx_cnt.sv
module pdc_idx_cnt #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         up_i,
  input  logic         dn_i,
  output logic [W-1:0] idx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_o <= '0;
    else if (load_i) idx_o <= load_val_i;
    else if (up_i)   idx_o <= idx_o + W'(1);
    else if (dn_i)   idx_o <= idx_o - W'(1);
  end
endmodule

// File: rtl/pdc_dist_cnt.sv
module pdc_dist_cnt #(
  parameter int unsigned W   = 7,
  parameter int unsigned MAX = 127
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] nxt_o
);
  localparam logic [W-1:0] CMAX = W'(MAX);

  assign nxt_o = (cnt_o == CMAX) ? CMAX : cnt_o + W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (inc_i)  cnt_o <= nxt_o;
  end

  // R4
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == CMAX && inc_i && !clr_i) |=> (cnt_o == CMAX));
endmodule

// File: rtl/pdc_mask_sel.sv
module pdc_mask_sel #(
  parameter int unsigned N = 128,
  parameter int unsigned W = 7
) (
  input  logic [N-1:0] use_i,
  input  logic [N-1:0] pil_i,
  input  logic [W-1:0] idx_i,
  output logic         pil_o
);
  logic [N-1:0] eff;
  assign eff   = use_i & pil_i;
  assign pil_o = eff[idx_i];
endmodule

// File: rtl/pdc_coef_mem.sv
module pdc_coef_mem #(
  parameter int unsigned N = 128,
  parameter int unsigned W = 7,
  parameter int unsigned A = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fill_i,
  input  logic         we_i,
  input  logic [A-1:0] waddr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [A-1:0] raddr_i,
  output logic [W-1:0] rdata_o
);
  logic [W-1:0] mem_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(N); i++) mem_q[i] <= '0;
    end else if (fill_i) begin
      for (int i = 0; i < int'(N); i++) mem_q[i] <= W'(1);
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/pdc_coef_gen.sv
module pdc_coef_gen #(
  parameter int unsigned NUM_SC = 128,
  localparam int unsigned IDX_W = $clog2(NUM_SC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [NUM_SC-1:0] use_mask_i,
  input  logic [NUM_SC-1:0] pilot_mask_i,
  output logic              busy_o,
  output logic              done_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [IDX_W-1:0]  rd_wgt_l_o,
  output logic [IDX_W-1:0]  rd_wgt_r_o
);
  import pdc_pkg::*;

  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(NUM_SC - 1);

  pdc_state_e        st_q, st_d;
  logic [NUM_SC-1:0] use_q, pil_q;
  logic              seen_q;
  logic [IDX_W-1:0]  last_q, first_q;

  logic [IDX_W-1:0]  idx, idx_ldv;
  logic              idx_ld, idx_up, idx_dn;
  logic              d_clr, d_inc;
  logic [IDX_W-1:0]  d_cnt, d_nxt;
  logic              pil_bit;
  logic              fill, r_we, l_we;
  logic [IDX_W-1:0]  wdat;
  logic              trim_r_go, trim_l_go;

  pdc_idx_cnt #(.W(IDX_W)) u_idx (
    .clk_i, .rst_ni, .load_i(idx_ld), .load_val_i(idx_ldv),
    .up_i(idx_up), .dn_i(idx_dn), .idx_o(idx)
  );

  pdc_dist_cnt #(.W(IDX_W), .MAX(NUM_SC - 1)) u_dist (
    .clk_i, .rst_ni, .clr_i(d_clr), .inc_i(d_inc), .cnt_o(d_cnt), .nxt_o(d_nxt)
  );

  pdc_mask_sel #(.N(NUM_SC), .W(IDX_W)) u_sel (
    .use_i(use_q), .pil_i(pil_q), .idx_i(idx), .pil_o(pil_bit)
  );

  pdc_coef_mem #(.N(NUM_SC), .W(IDX_W), .A(IDX_W)) u_mem_r (
    .clk_i, .rst_ni, .fill_i(fill), .we_i(r_we), .waddr_i(idx), .wdata_i(wdat),
    .raddr_i(rd_idx_i), .rdata_o(rd_wgt_r_o)
  );

  pdc_coef_mem #(.N(NUM_SC), .W(IDX_W), .A(IDX_W)) u_mem_l (
    .clk_i, .rst_ni, .fill_i(fill), .we_i(l_we), .waddr_i(idx), .wdata_i(wdat),
    .raddr_i(rd_idx_i), .rdata_o(rd_wgt_l_o)
  );

  assign trim_r_go = seen_q && (idx > last_q);
  assign trim_l_go = !seen_q || (idx < first_q);

  always_comb begin
    st_d    = st_q;
    idx_ld  = 1'b0;
    idx_ldv = '0;
    idx_up  = 1'b0;
    idx_dn  = 1'b0;
    d_clr   = 1'b0;
    d_inc   = 1'b0;
    fill    = 1'b0;
    r_we    = 1'b0;
    l_we    = 1'b0;
    wdat    = '0;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_INIT;
      ST_INIT: begin
        fill   = 1'b1;
        idx_ld = 1'b1;
        d_clr  = 1'b1;
        st_d   = ST_FWD;
      end
      ST_FWD: begin
        if (pil_bit) begin
          r_we  = 1'b1;
          d_clr = 1'b1;
        end else if (seen_q) begin
          r_we  = 1'b1;
          wdat  = d_nxt;
          d_inc = 1'b1;
        end
        if (idx == IDX_MAX) st_d = ST_TRIM_R;
        else                idx_up = 1'b1;
      end
      ST_TRIM_R: begin
        if (trim_r_go) begin
          r_we   = 1'b1;
          idx_dn = 1'b1;
        end else begin
          st_d    = ST_BWD;
          idx_ld  = 1'b1;
          idx_ldv = IDX_MAX;
          d_clr   = 1'b1;
        end
      end
      ST_BWD: begin
        if (pil_bit) begin
          l_we  = 1'b1;
          d_clr = 1'b1;
        end else if (seen_q) begin
          l_we  = 1'b1;
          wdat  = d_nxt;
          d_inc = 1'b1;
        end
        if (idx == '0) st_d = ST_TRIM_L;
        else           idx_dn = 1'b1;
      end
      ST_TRIM_L: begin
        if (trim_l_go) begin
          l_we = 1'b1;
          if (idx == IDX_MAX) st_d = ST_DONE;
          else                idx_up = 1'b1;
        end else begin
          st_d = ST_DONE;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      use_q   <= '0;
      pil_q   <= '0;
      seen_q  <= 1'b0;
      last_q  <= '0;
      first_q <= '0;
    end else begin
      st_q <= st_d;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          use_q <= use_mask_i;
          pil_q <= pilot_mask_i;
        end
        ST_INIT: seen_q <= 1'b0;
        ST_FWD: if (pil_bit) begin
          seen_q <= 1'b1;
          last_q <= idx;
        end
        ST_TRIM_R: if (!trim_r_go) seen_q <= 1'b0;
        ST_BWD: if (pil_bit) begin
          seen_q  <= 1'b1;
          first_q <= idx;
        end
        default: ;
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE) && (st_q != ST_DONE);
  assign done_o = (st_q == ST_DONE);

  // R1
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !done_o) |=> busy_o);

  // R2
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(use_q) && $stable(pil_q)));

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4
  pilot_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FWD && pil_bit) |-> (r_we && wdat == '0));

  // R4
  fwd_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FWD && $past(st_q) == ST_FWD) |-> (idx == IDX_W'($past(idx) + IDX_W'(1))));
endmodule

// File: tb/tb_pdc_coef_gen.sv
module tb_pdc_coef_gen;
  localparam int N = 128;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [N-1:0] use_m = '0;
  logic [N-1:0] pil_m = '0;
  logic         busy, done;
  logic [6:0]   rd_idx = '0;
  logic [6:0]   wl, wr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    int    idx;
    int    el;
    int    er;
    string tl;
    string tr;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  pdc_coef_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .use_mask_i(use_m), .pilot_mask_i(pil_m),
    .busy_o(busy), .done_o(done),
    .rd_idx_i(rd_idx), .rd_wgt_l_o(wl), .rd_wgt_r_o(wr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: compare each read result one edge after its address
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk(int'(wl) == e.el, e.tl, int'(wl), e.el);
      chk(int'(wr) == e.er, e.tr, int'(wr), e.er);
    end
  end

  task automatic push_expect(input logic [N-1:0] eff);
    bit has;
    has = |eff;
    for (int i = 0; i < N; i++) begin
      exp_t e;
      int lo, hi;
      lo = -1; hi = -1;
      for (int j = i; j >= 0; j--) if (eff[j] && lo < 0) lo = j;
      for (int j = i; j < N; j++)  if (eff[j] && hi < 0) hi = j;
      e.idx = i;
      if (!has) begin
        e.er = 1; e.el = 0;
        e.tl = $sformatf("R8 R10 left idx %0d", i);
        e.tr = $sformatf("R8 R10 right idx %0d", i);
      end else begin
        if (lo < 0)      begin e.er = 1;      e.tr = $sformatf("R5 right idx %0d", i); end
        else if (hi < 0) begin e.er = 0;      e.tr = $sformatf("R5 right idx %0d", i); end
        else             begin e.er = i - lo; e.tr = $sformatf("R4 R10 right idx %0d", i); end
        if (hi < 0)      begin e.el = 1;      e.tl = $sformatf("R7 left idx %0d", i); end
        else if (lo < 0) begin e.el = 0;      e.tl = $sformatf("R7 left idx %0d", i); end
        else             begin e.el = hi - i; e.tl = $sformatf("R6 R10 left idx %0d", i); end
      end
      @(negedge clk);
      rd_idx = 7'(i);
      sb_q.push_back(e);
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run_frame(input logic [N-1:0] u, input logic [N-1:0] p,
                           input bit intrude, input logic [N-1:0] u2, input logic [N-1:0] p2);
    int cyc;
    @(negedge clk);
    use_m = u; pil_m = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R1
    chk(busy == 1'b1, "R1 busy after start", int'(busy), 1);
    if (intrude) begin
      repeat (20) @(negedge clk);
      use_m = u2; pil_m = p2; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      use_m = '1; pil_m = '1;
    end
    wait_done(cyc);
    // R9
    chk(done == 1'b1 && cyc <= 390, "R9 done latency", cyc, 390);
    chk(busy == 1'b0, "R9 busy low with done", int'(busy), 0);
    @(negedge clk);
    chk(done == 1'b0, "R9 done single cycle", int'(done), 0);
    push_expect(u & p); // R3: only used pilot bits count
  endtask

  initial begin
    logic [N-1:0] u, p;
    repeat (3) @(negedge clk);
    // reset state
    chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    chk(done == 1'b0, "R9 reset done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 idle busy", int'(busy), 0);

    // spread pilots, all used
    u = '1; p = '0; p[5] = 1; p[20] = 1; p[60] = 1; p[100] = 1;
    run_frame(u, p, 0, '0, '0);

    // single pilot at lowest index
    p = '0; p[0] = 1;
    run_frame(u, p, 0, '0, '0);

    // single pilot at highest index
    p = '0; p[127] = 1;
    run_frame(u, p, 0, '0, '0);

    // R8: no pilot
    run_frame(u, '0, 0, '0, '0);

    // R3: pilot bits on unused subcarriers, adjacent pilots
    u = '1; u[10] = 0; u[90] = 0; u[0] = 0;
    p = '0; p[0] = 1; p[10] = 1; p[30] = 1; p[31] = 1; p[90] = 1; p[110] = 1;
    run_frame(u, p, 0, '0, '0);

    // R2: second start mid-frame must be ignored
    u = '1; p = '0; p[40] = 1; p[80] = 1;
    run_frame(u, p, 1, '1, 128'h1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule